// File: doc/BRIEF.md
# ADC Output Code Formatter

This block sits between a 10-bit pipelined converter core and the parallel data pins. On every sample clock it takes the raw code and two range flags from the core. When a flag is set it forces the code to the nearest end of scale and raises an out-of-range flag. It can also re-express the code in two's complement. The result then passes through a fixed delay line, so the output lands four clock edges after the input was taken. The delay matches the pipeline latency of the converter.

Three control bits from the register file shape the output. The first picks the number format for each sample as it enters. The second puts the data bus in high impedance without stopping the flag or valid outputs. The third is power-down, which flushes the delay line and holds every output at zero. A valid output tells the consumer when the delay line again carries real samples, after reset or after power-down ends.

Top module: `adc_code_fmt`

## Requirements
- R1: A sample taken with `under_flag` high leaves as unsigned code 0 (two's complement 0x200), whatever `raw_code` holds; `under_flag` wins when both flags are high.
- R2: A sample taken with only `over_flag` high leaves as unsigned code 1023 (two's complement 0x1FF).
- R3: `oor_out` is high in exactly the output cycle that carries a sample taken with either flag set, and low for in-range samples.
- R4: With `fmt_twos` low, an in-range code leaves unchanged across the whole range 0 to 1023, with bit 0 as the LSB and bit 9 as the MSB of both `raw_code` and `data_out`.
- R5: With `fmt_twos` high, the output is the unsigned code plus 512 modulo 1024 (MSB inverted), so 512 leaves as 0, 0 as 0x200 (-512) and 1023 as 0x1FF (511).
- R6: A sample present at rising edge n is on the outputs from just after edge n+3 until edge n+4.
- R7: `fmt_twos` is taken along with each sample; changing it does not alter samples already in the delay line.
- R8: With `out_disable` high, `data_out` is high impedance in the same cycle, while `oor_out` and `valid_out` keep being driven.
- R9: After any edge at which `power_down` is high, `data_out` (when enabled) is 0 and `oor_out` and `valid_out` are low.
- R10: `valid_out` rises only when the first sample taken after reset or power-down reaches the outputs, and stays high while samples keep flowing.
- R11: While `rst_n` is low, `data_out` is 0 and `oor_out` and `valid_out` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_code | input | 10 | Raw conversion result from the core |
| under_flag | input | 1 | Core input was below the valid range |
| over_flag | input | 1 | Core input was above the valid range |
| fmt_twos | input | 1 | 1 selects two's complement, 0 unsigned |
| out_disable | input | 1 | 1 puts the data bus in high impedance |
| power_down | input | 1 | 1 flushes and holds the delay line at zero |
| data_out | output | 10 | Formatted, delayed code (tri-stated) |
| oor_out | output | 1 | Out-of-range flag aligned with data_out |
| valid_out | output | 1 | Delay line carries a real sample |

## Verification
The assertions assume a delay of more than one stage. They also assume that `out_disable` and the range flags are plain levels, sampled only at the rising edge. The saturation-shape check reads the bus only while it is driven, because a disabled bus has no defined value. The stimulus changes every input at the falling edge and raises `out_disable` only while the rest of the traffic goes on. Both flags are driven high together, so the priority case is covered. Power-down is applied in the middle of a stream of samples, which tests the flush and the recovery of valid.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    typedef enum logic [1:0] {
        RNG_IN   = 2'd0,
        RNG_LOW  = 2'd1,
        RNG_HIGH = 2'd2
    } rng_e;

    // Bits carried next to the code in every delay stage: flag and valid tag.
    localparam int unsigned TAG_BITS = 2;

    function automatic rng_e classify(input logic low, input logic high);
        if (low)       return RNG_LOW;
        else if (high) return RNG_HIGH;
        else           return RNG_IN;
    endfunction

endpackage

// File: rtl/adc_fmt_front.sv
module adc_fmt_front
    import adc_fmt_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0]          raw_code,
    input  logic                  under_flag,
    input  logic                  over_flag,
    input  logic                  fmt_twos,
    output logic [W+TAG_BITS-1:0] beat
);

    rng_e         rng;
    logic [W-1:0] sat_code;
    logic [W-1:0] fmt_code;

    always_comb begin
        rng = classify(under_flag, over_flag);
        unique case (rng)
            RNG_LOW:  sat_code = '0;
            RNG_HIGH: sat_code = '1;
            default:  sat_code = raw_code;
        endcase
        // Offset-binary to two's complement: flip the sign position only.
        fmt_code = fmt_twos ? {~sat_code[W-1], sat_code[W-2:0]} : sat_code;
        beat     = {fmt_code, (rng != RNG_IN), 1'b1};
    end

endmodule

// File: rtl/adc_fmt_pipe.sv
module adc_fmt_pipe #(
    parameter int unsigned BW    = 12,
    parameter int unsigned DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          power_down,
    input  logic [BW-1:0] beat_in,
    output logic [BW-1:0] beat_out
);

    typedef struct packed {
        logic [DEPTH-1:0][BW-1:0] stg;
    } pipe_s;

    pipe_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (power_down) begin
            st_d.stg = '0;
        end else begin
            st_d.stg[0] = beat_in;
            for (int i = 1; i < DEPTH; i++) begin
                st_d.stg[i] = st_q.stg[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_out = st_q.stg[DEPTH-1];

endmodule

// File: rtl/adc_fmt_drive.sv
module adc_fmt_drive
    import adc_fmt_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic [W+TAG_BITS-1:0] beat,
    input  logic                  out_disable,
    output logic [W-1:0]          data_out,
    output logic                  oor_out,
    output logic                  valid_out
);

    assign data_out  = out_disable ? {W{1'bz}} : beat[W+TAG_BITS-1:TAG_BITS];
    assign oor_out   = beat[1];
    assign valid_out = beat[0];

endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt
    import adc_fmt_pkg::*;
#(
    parameter int unsigned CODE_W  = 10,
    parameter int unsigned LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] raw_code,
    input  logic              under_flag,
    input  logic              over_flag,
    input  logic              fmt_twos,
    input  logic              out_disable,
    input  logic              power_down,
    output logic [CODE_W-1:0] data_out,
    output logic              oor_out,
    output logic              valid_out
);

    localparam int unsigned BEAT_W = CODE_W + TAG_BITS;

    logic [BEAT_W-1:0] beat_in;
    logic [BEAT_W-1:0] beat_out;

    adc_fmt_front #(.W(CODE_W)) u_front (
        .raw_code   (raw_code),
        .under_flag (under_flag),
        .over_flag  (over_flag),
        .fmt_twos   (fmt_twos),
        .beat       (beat_in)
    );

    adc_fmt_pipe #(.BW(BEAT_W), .DEPTH(LATENCY)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .power_down (power_down),
        .beat_in    (beat_in),
        .beat_out   (beat_out)
    );

    adc_fmt_drive #(.W(CODE_W)) u_drive (
        .beat        (beat_out),
        .out_disable (out_disable),
        .data_out    (data_out),
        .oor_out     (oor_out),
        .valid_out   (valid_out)
    );

endmodule

// File: rtl/adc_fmt_chk.sv
module adc_fmt_chk #(
    parameter int unsigned W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         power_down,
    input logic         out_disable,
    input logic [W-1:0] data_out,
    input logic         oor_out,
    input logic         valid_out
);

    // R9: power-down empties the outputs one edge later
    p_pd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (!oor_out && !valid_out));

    // R10: valid cannot return in the cycle right after power-down
    p_release_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(power_down) |-> !valid_out);

    // R3: the range flag only rides on a real sample
    p_oor_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oor_out |-> valid_out);

    // R1 / R2: a flagged sample has all bits below the MSB equal
    p_sat_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (oor_out && !out_disable) |-> (data_out[W-2:0] == '0 || data_out[W-2:0] == '1));

endmodule

bind adc_code_fmt adc_fmt_chk #(.W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .power_down  (power_down),
    .out_disable (out_disable),
    .data_out    (data_out),
    .oor_out     (oor_out),
    .valid_out   (valid_out)
);

// File: tb/tb_adc_code_fmt.sv
module tb_adc_code_fmt;

    localparam int W   = 10;
    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] raw;
    logic         under, over, fmt, dis, pd;
    tri1  [W-1:0] bus;
    logic         oor, vld;

    always #2 clk = ~clk;

    adc_code_fmt dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_code    (raw),
        .under_flag  (under),
        .over_flag   (over),
        .fmt_twos    (fmt),
        .out_disable (dis),
        .power_down  (pd),
        .data_out    (bus),
        .oor_out     (oor),
        .valid_out   (vld)
    );

    int checks = 0;
    int errors = 0;
    string phase = "";

    logic [W-1:0] m_code [LAT];
    logic         m_oor  [LAT];
    logic         m_vld  [LAT];
    string        m_tag  [LAT];

    function automatic logic [W-1:0] expect_code(input int c, input logic u, input logic o, input logic f);
        int s;
        s = u ? 0 : (o ? 1023 : c);
        if (f) s = (s + 512) % 1024;
        return s[W-1:0];
    endfunction

    function automatic string entry_tag(input logic u, input logic o, input logic f);
        if (u) return "R1";
        if (o) return "R2";
        if (phase != "") return phase;
        return f ? "R5" : "R4";
    endfunction

    // Reference delay line, derived from R6/R9/R10/R11
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                m_code[i] <= '0; m_oor[i] <= 1'b0; m_vld[i] <= 1'b0; m_tag[i] <= "R11";
            end
        end else if (pd) begin
            for (int i = 0; i < LAT; i++) begin
                m_code[i] <= '0; m_oor[i] <= 1'b0; m_vld[i] <= 1'b0; m_tag[i] <= "R9";
            end
        end else begin
            for (int i = LAT - 1; i > 0; i--) begin
                m_code[i] <= m_code[i-1]; m_oor[i] <= m_oor[i-1];
                m_vld[i]  <= m_vld[i-1];  m_tag[i] <= m_tag[i-1];
            end
            m_code[0] <= expect_code(int'(raw), under, over, fmt);
            m_oor[0]  <= under | over;
            m_vld[0]  <= 1'b1;
            m_tag[0]  <= entry_tag(under, over, fmt);
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outs();
        string t;
        t = m_tag[LAT-1];
        if (dis) chk("R8", bus, '1);
        else     chk(t, bus, m_code[LAT-1]);
        if (t == "R9" || t == "R11") begin
            chk(t, {{(W-1){1'b0}}, oor}, {{(W-1){1'b0}}, m_oor[LAT-1]});
            chk(t, {{(W-1){1'b0}}, vld}, {{(W-1){1'b0}}, m_vld[LAT-1]});
        end else begin
            chk(dis ? "R8" : "R3", {{(W-1){1'b0}}, oor}, {{(W-1){1'b0}}, m_oor[LAT-1]});
            chk(dis ? "R8" : "R10", {{(W-1){1'b0}}, vld}, {{(W-1){1'b0}}, m_vld[LAT-1]});
        end
    endtask

    task automatic cycle(input int c, input logic u, input logic o, input logic f,
                         input logic d, input logic p);
        @(negedge clk);
        check_outs();
        raw = c[W-1:0]; under = u; over = o; fmt = f; dis = d; pd = p;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; raw = '0; under = 0; over = 0; fmt = 0; dis = 0; pd = 0;
        // R11: reset state
        repeat (3) begin
            @(negedge clk);
            check_outs();
        end
        rst_n = 1'b1;

        // R4: unsigned sweep, R10: valid rises after fill
        for (int c = 0; c < 1024; c++) cycle(c, 0, 0, 0, 0, 0);
        // R5: two's complement sweep
        for (int c = 0; c < 1024; c++) cycle(c, 0, 0, 1, 0, 0);
        // R1 R2 R3: all flag combinations in both formats
        for (int c = 0; c < 256; c++) cycle((c * 37) % 1024, c[0], c[1], c[2], 0, 0);
        // R7: format flips every sample
        phase = "R7";
        for (int c = 0; c < 64; c++) cycle(c * 16, 0, 0, c[0], 0, 0);
        // R9: power-down in the middle of traffic
        phase = "";
        for (int c = 0; c < 6; c++) cycle(700 + c, c[0], 0, 0, 0, 1);
        // R6 R10: marker after release
        phase = "R6";
        cycle(341, 0, 0, 0, 0, 0);
        for (int c = 0; c < 8; c++) cycle(c, 0, 0, 0, 0, 0);
        // R8: bus released while flagged samples keep flowing
        phase = "";
        for (int c = 0; c < 10; c++) cycle(5, 1, 0, 0, 1, 0);
        for (int c = 0; c < 8; c++) cycle(100 + c, 0, 0, 0, 0, 0);
        finish_run();
    end

endmodule